// File: doc/BRIEF.md
# Gain-Ranging Sample Scaler and Channel Steerer

This block sits at the very front of a digital receiver datapath. Each clock it may accept one converter sample made of a signed 16-bit mantissa, a 3-bit unsigned gain code and a select line. It turns the gain code into a right-shift amount and produces an attenuated, sign-extended 24-bit sample. The shift amount is the gain code plus a programmable offset, taken modulo 8. An invert option reverses the sense of the code, for converters whose code rises as the signal gets stronger.

Each output sample carries a valid strobe and a 2-bit channel tag. The tag comes from the programmed input mode together with the select line. The three modes are single real channel, two interleaved real channels (diversity), and one complex channel with interleaved I and Q. A narrow write-only register port holds the mode and the gain-code controls.

With a fixed-point converter, the gain code is tied to zero and the offset and invert are left at zero. The mantissa then passes through untouched.

Top module: `gr_input_scaler`

## Requirements
- R1: While reset is asserted, and right after it, out_vld, out_data and out_tag are 0. The configuration resets to single real mode with offset 0 and invert 0.
- R2: A sample presented with in_vld high before rising edge n appears with out_vld high just after edge n+1. A new sample is accepted on every clock, with no gaps.
- R3: With invert 0, the shift is (code + offset) mod 8. out_data is {mantissa, 8'h00} shifted right arithmetically by that amount.
- R4: With invert 1, the shift is (7 - code + offset) mod 8, applied in the same way as in R3.
- R5: With offset 0, invert 0 and code 0, out_data[23:8] equals the mantissa and out_data[7:0] is 0.
- R6: For every shift from 0 to 7, the full mantissa is kept in the output and out_data[23] equals the mantissa sign bit.
- R7: A write to address 0x300 sets the mode from data bits [1:0]. The codes are 0 single real, 1 diversity, 2 complex, and 3, which behaves as single real. In single real mode out_tag is 0 whatever in_sel is.
- R8: In diversity mode, in_sel 0 gives tag 0 (channel A) and in_sel 1 gives tag 1 (channel B).
- R9: In complex mode, in_sel 0 gives tag 2 (in-phase) and in_sel 1 gives tag 3 (quadrature).
- R10: A write to address 0x305 sets the offset from data bits [7:5] and the invert from bit 4. Bits [3:0] are ignored, and writes to any other address change nothing.
- R11: A sample presented in the same cycle as a register write is processed with the old settings. The next sample uses the new ones.
- R12: Whenever out_vld is 0, out_data and out_tag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| in_vld | input | 1 | Input sample valid |
| in_mant | input | 16 | Two's complement mantissa, MSB-justified |
| in_exp | input | 3 | Unsigned gain code |
| in_sel | input | 1 | Channel / I-Q select |
| out_vld | output | 1 | Output sample valid |
| out_tag | output | 2 | Channel tag (0 A, 1 B, 2 I, 3 Q) |
| out_data | output | 24 | Scaled sample |

## Verification
Two situations are the hardest to reach from the ports. The first is a register write that lands in the same cycle as a valid sample, where the old and new settings must split cleanly between adjacent samples. The stimulus forces this by issuing writes together with valid samples and by changing the offset and invert on consecutive samples. The second is offset values that make the modulo-8 sum wrap past 7. The stimulus covers it with sweeps of all eight codes under several offsets, in both invert settings, using extreme mantissas so that any lost bit or lost sign shows at the maximum shift.

// File: rtl/gr_scaler_pkg.sv
package gr_scaler_pkg;

   typedef enum logic [1:0] {
      MODE_REAL = 2'd0,
      MODE_DIV  = 2'd1,
      MODE_CPLX = 2'd2,
      MODE_RSVD = 2'd3
   } in_mode_e;

   typedef enum logic [1:0] {
      TAG_A = 2'd0,
      TAG_B = 2'd1,
      TAG_I = 2'd2,
      TAG_Q = 2'd3
   } chan_tag_e;

   localparam int unsigned TAG_W  = 2;
   localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/gr_cfg_regs.sv
module gr_cfg_regs
   import gr_scaler_pkg::*;
#(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned OFF_LSB = 5,
   parameter int unsigned INV_BIT = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 'h300,
   parameter logic [ADDR_W-1:0] ECTL_ADDR = 'h305
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output in_mode_e          mode_o,
   output logic [EXP_W-1:0]  off_o,
   output logic              inv_o
);

   if (OFF_LSB + EXP_W > DATA_W) begin : g_bad_off
      $error("offset field does not fit in the data word");
   end
   if (INV_BIT >= DATA_W) begin : g_bad_inv
      $error("invert bit lies outside the data word");
   end
   if (INV_BIT >= OFF_LSB && INV_BIT < OFF_LSB + EXP_W) begin : g_overlap
      $error("invert bit overlaps the offset field");
   end
   if (MODE_ADDR == ECTL_ADDR) begin : g_addr_clash
      $error("register addresses must differ");
   end
   if (DATA_W < MODE_W) begin : g_bad_dw
      $error("data word narrower than the mode field");
   end

   logic sel_mode;
   logic sel_ectl;
   logic wdata_unused;

   assign sel_mode     = wr_en && (addr == MODE_ADDR);
   assign sel_ectl     = wr_en && (addr == ECTL_ADDR);
   assign wdata_unused = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= MODE_REAL;
      end else if (sel_mode) begin
         mode_o <= in_mode_e'(wdata[MODE_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_o <= '0;
         inv_o <= 1'b0;
      end else if (sel_ectl) begin
         off_o <= wdata[OFF_LSB +: EXP_W];
         inv_o <= wdata[INV_BIT];
      end
   end

endmodule

// File: rtl/gr_exp_shift.sv
module gr_exp_shift #(
   parameter int unsigned MANT_W      = 16,
   parameter int unsigned EXP_W       = 3,
   parameter int unsigned OUT_W       = 24,
   parameter int unsigned SHIFT_STYLE = 1
) (
   input  logic [MANT_W-1:0] mant_i,
   input  logic [EXP_W-1:0]  code_i,
   input  logic [EXP_W-1:0]  off_i,
   input  logic              inv_i,
   output logic [OUT_W-1:0]  data_o
);

   localparam int unsigned PAD_W     = OUT_W - MANT_W;
   localparam int unsigned MAX_SHIFT = (1 << EXP_W) - 1;

   if (OUT_W < MANT_W + MAX_SHIFT) begin : g_bad_width
      $error("output too narrow to keep all mantissa bits at the largest shift");
   end
   if (SHIFT_STYLE > 1) begin : g_bad_style
      $error("SHIFT_STYLE must be 0 or 1");
   end

   logic [EXP_W-1:0]        code_dir;
   logic [EXP_W-1:0]        amt;
   logic signed [OUT_W-1:0] wide;

   // (2^EXP_W - 1 - code) equals the bitwise complement of the code
   assign code_dir = inv_i ? ~code_i : code_i;
   assign amt      = code_dir + off_i;
   assign wide     = {mant_i, {PAD_W{1'b0}}};

   if (SHIFT_STYLE == 0) begin : g_direct
      assign data_o = wide >>> amt;
   end else begin : g_staged
      logic signed [OUT_W-1:0] stage [0:EXP_W];
      assign stage[0] = wide;
      for (genvar k = 0; k < EXP_W; k++) begin : g_st
         assign stage[k+1] = amt[k] ? (stage[k] >>> (1 << k)) : stage[k];
      end
      assign data_o = stage[EXP_W];
   end

endmodule

// File: rtl/gr_chan_steer.sv
module gr_chan_steer
   import gr_scaler_pkg::*;
(
   input  in_mode_e  mode_i,
   input  logic      sel_i,
   output chan_tag_e tag_o
);

   always_comb begin
      unique case (mode_i)
         MODE_DIV:  tag_o = sel_i ? TAG_B : TAG_A;
         MODE_CPLX: tag_o = sel_i ? TAG_Q : TAG_I;
         default:   tag_o = TAG_A;
      endcase
   end

endmodule

// File: rtl/gr_input_scaler.sv
module gr_input_scaler
   import gr_scaler_pkg::*;
#(
   parameter int unsigned MANT_W      = 16,
   parameter int unsigned EXP_W       = 3,
   parameter int unsigned OUT_W       = 24,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OFF_LSB     = 5,
   parameter int unsigned INV_BIT     = 4,
   parameter int unsigned SHIFT_STYLE = 1,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 'h300,
   parameter logic [ADDR_W-1:0] ECTL_ADDR = 'h305
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              in_vld,
   input  logic [MANT_W-1:0] in_mant,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic              in_sel,
   output logic              out_vld,
   output logic [TAG_W-1:0]  out_tag,
   output logic [OUT_W-1:0]  out_data
);

   if (MANT_W < 2) begin : g_bad_mant
      $error("mantissa must be at least two bits");
   end
   if (EXP_W < 1) begin : g_bad_exp
      $error("gain code must be at least one bit");
   end

   in_mode_e         cfg_mode;
   logic [EXP_W-1:0] cfg_off;
   logic             cfg_inv;

   gr_cfg_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .EXP_W     (EXP_W),
      .OFF_LSB   (OFF_LSB),
      .INV_BIT   (INV_BIT),
      .MODE_ADDR (MODE_ADDR),
      .ECTL_ADDR (ECTL_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .mode_o (cfg_mode),
      .off_o  (cfg_off),
      .inv_o  (cfg_inv)
   );

   // Stage 1: capture the sample together with the settings in force before
   // any write of the same cycle lands.
   logic              s1_vld;
   logic [MANT_W-1:0] s1_mant;
   logic [EXP_W-1:0]  s1_code;
   logic              s1_sel;
   in_mode_e          s1_mode;
   logic [EXP_W-1:0]  s1_off;
   logic              s1_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_mant <= '0;
         s1_code <= '0;
         s1_sel  <= 1'b0;
         s1_mode <= MODE_REAL;
         s1_off  <= '0;
         s1_inv  <= 1'b0;
      end else begin
         s1_vld  <= in_vld;
         s1_mant <= in_mant;
         s1_code <= in_exp;
         s1_sel  <= in_sel;
         s1_mode <= cfg_mode;
         s1_off  <= cfg_off;
         s1_inv  <= cfg_inv;
      end
   end

   logic [OUT_W-1:0] scaled;
   chan_tag_e        tag_nx;

   gr_exp_shift #(
      .MANT_W      (MANT_W),
      .EXP_W       (EXP_W),
      .OUT_W       (OUT_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_shift (
      .mant_i (s1_mant),
      .code_i (s1_code),
      .off_i  (s1_off),
      .inv_i  (s1_inv),
      .data_o (scaled)
   );

   gr_chan_steer u_steer (
      .mode_i (s1_mode),
      .sel_i  (s1_sel),
      .tag_o  (tag_nx)
   );

   // Stage 2: registered outputs, zero while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_tag  <= '0;
         out_data <= '0;
      end else begin
         out_vld  <= s1_vld;
         out_tag  <= s1_vld ? tag_nx : TAG_A;
         out_data <= s1_vld ? scaled : '0;
      end
   end

endmodule

// File: rtl/gr_input_scaler_chk.sv
module gr_input_scaler_chk #(
   parameter int unsigned MANT_W  = 16,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned OUT_W   = 24,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OFF_LSB = 5,
   parameter int unsigned INV_BIT = 4,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 'h300,
   parameter logic [ADDR_W-1:0] ECTL_ADDR = 'h305
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              in_vld,
   input logic [MANT_W-1:0] in_mant,
   input logic              in_sel,
   input logic              out_vld,
   input logic [1:0]        out_tag,
   input logic [OUT_W-1:0]  out_data,
   input logic [1:0]        cfg_mode,
   input logic [EXP_W-1:0]  cfg_off,
   input logic              cfg_inv
);

   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

   assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (out_data == '0 && out_tag == 2'd0));

   assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && out_vld) |-> (out_data[OUT_W-1] == $past(in_mant[MANT_W-1], 2)));

   assert_sel_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && out_vld && out_tag != 2'd0) |-> (out_tag[0] == $past(in_sel, 2)));

   assert_ectl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == ECTL_ADDR) |=>
         (cfg_off == $past(cfg_wdata[OFF_LSB +: EXP_W]) && cfg_inv == $past(cfg_wdata[INV_BIT])));

   assert_ectl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr_en && cfg_addr == ECTL_ADDR) |=> ($stable(cfg_off) && $stable(cfg_inv)));

   assert_mode_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == MODE_ADDR) |=> (cfg_mode == $past(cfg_wdata[1:0])));

endmodule

bind gr_input_scaler gr_input_scaler_chk #(
   .MANT_W    (MANT_W),
   .EXP_W     (EXP_W),
   .OUT_W     (OUT_W),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .OFF_LSB   (OFF_LSB),
   .INV_BIT   (INV_BIT),
   .MODE_ADDR (MODE_ADDR),
   .ECTL_ADDR (ECTL_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr_en (cfg_wr_en),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .in_vld    (in_vld),
   .in_mant   (in_mant),
   .in_sel    (in_sel),
   .out_vld   (out_vld),
   .out_tag   (out_tag),
   .out_data  (out_data),
   .cfg_mode  (cfg_mode),
   .cfg_off   (cfg_off),
   .cfg_inv   (cfg_inv)
);

// File: tb/gr_input_scaler_test.sv
`timescale 1ns/1ps
module gr_input_scaler_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [9:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        in_vld = 1'b0;
   logic [15:0] in_mant = '0;
   logic [2:0]  in_exp = '0;
   logic        in_sel = 1'b0;
   logic        out_vld;
   logic [1:0]  out_tag;
   logic [23:0] out_data;

   gr_input_scaler uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_vld(in_vld), .in_mant(in_mant), .in_exp(in_exp),
      .in_sel(in_sel), .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // behavioural model state
   int m_mode = 0;
   int m_off = 0;
   bit m_inv = 1'b0;

   bit          p_live [2];
   bit          p_vld  [2];
   logic [23:0] p_data [2];
   logic [1:0]  p_tag  [2];
   string       p_lbl  [2];

   function automatic logic [23:0] ref_scale(logic [15:0] m, int e, int off, bit inv);
      int eff;
      longint v;
      eff = inv ? ((7 - e + off) % 8) : ((e + off) % 8);
      v = longint'($signed(m)) * 256;
      v = v >>> eff;
      return v[23:0];
   endfunction

   function automatic logic [1:0] ref_tag(int mode, bit s);
      if (mode == 1) return s ? 2'd1 : 2'd0;
      if (mode == 2) return s ? 2'd3 : 2'd2;
      return 2'd0;
   endfunction

   task automatic check(string lbl, bit ok, string got, string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %s expected %s", lbl, got, exp);
      end
   endtask

   task automatic cycle(bit v, logic [15:0] m, int e, bit s,
                        bit w, logic [9:0] a, logic [7:0] d, string lbl);
      @(negedge clk);
      if (p_live[1])
         check(p_lbl[1],
               out_vld == p_vld[1] && out_tag == p_tag[1] && out_data == p_data[1],
               $sformatf("vld=%b tag=%0d data=%h", out_vld, out_tag, out_data),
               $sformatf("vld=%b tag=%0d data=%h", p_vld[1], p_tag[1], p_data[1]));
      p_live[1] = p_live[0];
      p_vld[1]  = p_vld[0];
      p_tag[1]  = p_tag[0];
      p_data[1] = p_data[0];
      p_lbl[1]  = p_lbl[0];
      p_live[0] = 1'b1;
      p_vld[0]  = v;
      p_tag[0]  = v ? ref_tag(m_mode, s) : 2'd0;
      p_data[0] = v ? ref_scale(m, e, m_off, m_inv) : 24'd0;
      p_lbl[0]  = lbl;
      if (w) begin
         if (a == 10'h300) m_mode = int'(d[1:0]);
         if (a == 10'h305) begin
            m_off = int'(d[7:5]);
            m_inv = d[4];
         end
      end
      in_vld    = v;
      in_mant   = m;
      in_exp    = 3'(e);
      in_sel    = s;
      cfg_wr_en = w;
      cfg_addr  = a;
      cfg_wdata = d;
   endtask

   task automatic sample(logic [15:0] m, int e, bit s, string lbl);
      cycle(1'b1, m, e, s, 1'b0, 10'h0, 8'h0, lbl);
   endtask

   task automatic wr(logic [9:0] a, logic [7:0] d, string lbl);
      cycle(1'b0, 16'h0, 0, 1'b0, 1'b1, a, d, lbl);
   endtask

   task automatic idle(int n, string lbl);
      for (int i = 0; i < n; i++) cycle(1'b0, 16'h0, 0, 1'b0, 1'b0, 10'h0, 8'h0, lbl);
   endtask

   task automatic sweep(string lbl);
      for (int e = 0; e < 8; e++) begin
         sample(16'h8000, e, 1'b0, lbl);
         sample(16'h7FFF, e, 1'b1, lbl);
         sample(16'(($urandom % 65536)), e, 1'b0, lbl);
      end
   endtask

   initial begin
      for (int i = 0; i < 2; i++) p_live[i] = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", out_vld == 1'b0 && out_tag == 2'd0 && out_data == 24'd0,
            $sformatf("vld=%b tag=%0d data=%h", out_vld, out_tag, out_data),
            "vld=0 tag=0 data=000000");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R1");

      // fixed-point pass-through with reset configuration
      sample(16'h0000, 0, 1'b1, "R5");
      sample(16'h8000, 0, 1'b0, "R5");
      sample(16'h7FFF, 0, 1'b1, "R5");
      sample(16'hFFF0, 0, 1'b0, "R5");
      for (int i = 0; i < 6; i++) sample(16'(($urandom % 65536)), 0, 1'(i), "R5");

      // invert 0, several offsets incl. wrap
      sweep("R3");
      wr(10'h305, 8'b011_0_0000, "R3");
      sweep("R3");
      wr(10'h305, 8'b111_0_0000, "R6");
      sweep("R6");

      // invert 1
      wr(10'h305, 8'b000_1_0000, "R4");
      sweep("R4");
      wr(10'h305, 8'b101_1_0000, "R4");
      sweep("R4");

      // ignored bits and foreign address
      wr(10'h305, 8'b010_0_1111, "R10");
      sweep("R10");
      wr(10'h301, 8'hFF, "R10");
      wr(10'h304, 8'hFF, "R10");
      wr(10'h306, 8'hFF, "R10");
      sweep("R10");

      // modes
      wr(10'h305, 8'h00, "R7");
      for (int i = 0; i < 4; i++) sample(16'h1234 + 16'(i), i, 1'(i), "R7");
      wr(10'h300, 8'h01, "R8");
      for (int i = 0; i < 6; i++) sample(16'hA5A5 ^ 16'(i), i, 1'(i), "R8");
      wr(10'h300, 8'hFE, "R9");
      for (int i = 0; i < 6; i++) sample(16'h5A5A ^ 16'(i), i, 1'(i), "R9");
      wr(10'h300, 8'h03, "R7");
      for (int i = 0; i < 4; i++) sample(16'h0F0F + 16'(i), i, 1'(i), "R7");
      wr(10'h300, 8'h00, "R7");
      sample(16'h4321, 1, 1'b1, "R7");

      // write coinciding with a valid sample
      wr(10'h300, 8'h02, "R11");
      cycle(1'b1, 16'hC000, 2, 1'b1, 1'b1, 10'h305, 8'b100_1_0000, "R11");
      sample(16'hC000, 2, 1'b1, "R11");
      cycle(1'b1, 16'h4000, 5, 1'b0, 1'b1, 10'h300, 8'h01, "R11");
      sample(16'h4000, 5, 1'b1, "R11");
      cycle(1'b1, 16'h8001, 7, 1'b1, 1'b1, 10'h305, 8'h00, "R11");
      sample(16'h8001, 7, 1'b1, "R11");

      // back-to-back stream with gaps
      for (int i = 0; i < 40; i++) begin
         if (i % 7 == 3) idle(1, "R12");
         sample(16'(($urandom % 65536)), int'($urandom % 8), 1'($urandom % 2), "R2");
      end
      idle(3, "R12");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual hung expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule